// File: doc/BRIEF.md
# Segmented Page Map Register File

This block translates a 64 KB CPU address space into physical pages. The space is cut into sixteen 4 KB pages, and the top four bits of a CPU address pick one of them. A table holds several segments of sixteen page entries. One segment is active at a time. When mapping is turned on, the lookup port returns the physical page that the active segment stores for the given nibble. When mapping is off, the lookup port returns the nibble itself with the upper page bits cleared.

Software reaches the block through a small byte-wide register window. Sixteen offsets map onto the entries of the active segment. Further registers hold:
- the segment select;
- an 8-bit window offset;
- a control register with three flags: map enable, window enable and boot-RAM select;
- a speed register with one flag, the fast-map mode.

The flags and the window offset are driven out to the surrounding decode logic. The block also gives a registered CPU clock selection code. This code is formed from the map enable, the fast-map mode and the CPU speed input.

Top module: `mmap_regfile`

## Requirements
- R1: A write to offset 0x80+k (k = 0..15) stores the low 6 bits of the data in entry k of the active segment. A read of that offset returns the stored value, with bits 7:6 reading as 0.
- R2: A write to offset 0x90 selects the active segment from data bits 1:0, and reads of 0x90 return that value zero-extended. Entries of one segment are not changed by writes made while another segment is active.
- R3: Offset 0x92 is an 8-bit window offset register. It can be read back and is driven on `win_offset`.
- R4: A write to offset 0x93 loads three flags from the data: boot-RAM select from bit 0, window enable from bit 6 and map enable from bit 7. A read of 0x93 returns 0x3E with bits 0, 6 and 7 taken from those flags. The flags are driven on `boot_ram`, `win_en` and `map_en`.
- R5: Offset 0x94 bit 0 is the fast-map mode flag. A read of 0x94 returns 0xFE with bit 0 taken from the flag.
- R6: When map enable is set, `phys_page` equals the entry of the active segment indexed by `cpu_addr_hi`. When map enable is clear, `phys_page` equals `cpu_addr_hi` with bits 5:4 zero.
- R7: `clk_sel` is a registered 3-bit code:
  - 0 selects 1.095 MHz (slow, map off);
  - 1 selects 1.794 MHz (fast, map off);
  - 2 selects 0.955 MHz (slow, map on);
  - 3 selects 1.565 MHz (fast, map on);
  - 4 selects 1.230 MHz (slow, map on, fast-map);
  - 5 selects 2.016 MHz (fast, map on, fast-map).

  Bit 0 is `cpu_fast`. The code takes the new value at the same clock edge that writes the control register, the speed register or a new `cpu_fast` level. Codes 6 and 7 never occur.
- R8: After reset:
  - map enable, window enable, boot-RAM select and fast-map mode are all clear;
  - the segment select, the window offset and every entry are 0;
  - `clk_sel` is 0.
- R9: Offsets outside 0x80–0x90 and 0x92–0x94 read as 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cpu_addr_hi | input | 4 | Top nibble of the CPU address |
| phys_page | output | 6 | Translated physical page |
| cpu_fast | input | 1 | CPU speed request (1 = fast) |
| win_offset | output | 8 | Window offset register |
| win_en | output | 1 | Window enable flag |
| boot_ram | output | 1 | Boot-RAM select flag |
| map_en | output | 1 | Map enable flag |
| clk_sel | output | 3 | CPU clock selection code |

## Verification
A wrong segment register shows up in two places, with no delay:
- the very next read of any entry offset returns the wrong value;
- `phys_page` takes the wrong value for every nibble once mapping is on.

A lost or misplaced control flag changes the 0x93 read-back and the matching flag pin on the cycle after the write. It also changes `clk_sel` one edge after the write. A corrupted entry is seen only when that entry is read or translated, so the bench goes back to earlier segments after writing to others.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

   // register offsets inside the byte window
   localparam logic [7:0] OFF_SEG   = 8'h90;
   localparam logic [7:0] OFF_WIN   = 8'h92;
   localparam logic [7:0] OFF_CTRL  = 8'h93;
   localparam logic [7:0] OFF_SPEED = 8'h94;
   localparam logic [3:0] TBL_NIB   = 4'h8;

   // control register bit positions
   localparam int CTRL_BOOT = 0;
   localparam int CTRL_WIN  = 6;
   localparam int CTRL_MAP  = 7;
   localparam logic [7:0] CTRL_FILL  = 8'h3E;
   localparam logic [7:0] SPEED_FILL = 8'hFE;

   typedef enum logic [2:0] {
      CK_SLOW      = 3'd0,
      CK_FAST      = 3'd1,
      CK_MAP_SLOW  = 3'd2,
      CK_MAP_FAST  = 3'd3,
      CK_FMAP_SLOW = 3'd4,
      CK_FMAP_FAST = 3'd5
   } clk_code_e;

   typedef struct packed {
      logic map_on;
      logic win_on;
      logic boot_ram;
      logic fast_map;
   } mmap_flags_t;

   function automatic clk_code_e pick_clock(input mmap_flags_t f, input logic fast);
      clk_code_e c;
      if (!f.map_on)
         c = fast ? CK_FAST : CK_SLOW;
      else if (f.fast_map)
         c = fast ? CK_FMAP_FAST : CK_FMAP_SLOW;
      else
         c = fast ? CK_MAP_FAST : CK_MAP_SLOW;
      return c;
   endfunction

endpackage

// File: rtl/mmap_ctrl.sv
module mmap_ctrl
   import mmap_pkg::*;
#(
   parameter int SEG_BITS = 2,
   parameter int WIN_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [7:0]          bus_addr,
   input  logic [7:0]          bus_wdata,
   input  logic                cpu_fast,
   output logic [SEG_BITS-1:0] seg_q,
   output logic [WIN_W-1:0]    win_q,
   output mmap_flags_t         flags_q,
   output logic [2:0]          clk_sel
);

   initial assert (WIN_W == 8);
   initial assert (SEG_BITS >= 1 && SEG_BITS <= 4);

   logic        wr_seg, wr_win, wr_ctrl, wr_speed;
   mmap_flags_t flags_d;
   clk_code_e   code_q;

   assign wr_seg   = bus_we && (bus_addr == OFF_SEG);
   assign wr_win   = bus_we && (bus_addr == OFF_WIN);
   assign wr_ctrl  = bus_we && (bus_addr == OFF_CTRL);
   assign wr_speed = bus_we && (bus_addr == OFF_SPEED);

   always_comb begin
      flags_d = flags_q;
      if (wr_ctrl) begin
         flags_d.map_on   = bus_wdata[CTRL_MAP];
         flags_d.win_on   = bus_wdata[CTRL_WIN];
         flags_d.boot_ram = bus_wdata[CTRL_BOOT];
      end
      if (wr_speed)
         flags_d.fast_map = bus_wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q   <= '0;
         win_q   <= '0;
         flags_q <= '0;
         code_q  <= CK_SLOW;
      end else begin
         if (wr_seg) seg_q <= bus_wdata[SEG_BITS-1:0];
         if (wr_win) win_q <= bus_wdata;
         flags_q <= flags_d;
         code_q  <= pick_clock(flags_d, cpu_fast);
      end
   end

   assign clk_sel = code_q;

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == OFF_SEG) |=> $stable(seg_q)); // R2
   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == OFF_WIN) |=> $stable(win_q)); // R3
   AST_CLK_FOLLOWS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFF_CTRL) |=> ((clk_sel[2:1] != 2'b00) == $past(bus_wdata[CTRL_MAP]))); // R7
   AST_CLK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_sel[2] && clk_sel[1])); // R7
   AST_CLK_SPEED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (clk_sel[0] == $past(cpu_fast))); // R7

endmodule

// File: rtl/mmap_table.sv
module mmap_table #(
   parameter int SEG_BITS = 2,
   parameter int IDX_BITS = 4,
   parameter int PAGE_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_BITS-1:0] seg,
   input  logic [IDX_BITS-1:0] wr_idx,
   input  logic [PAGE_W-1:0]   wr_page,
   input  logic [IDX_BITS-1:0] rd_idx,
   output logic [PAGE_W-1:0]   rd_page,
   input  logic [IDX_BITS-1:0] lk_idx,
   output logic [PAGE_W-1:0]   lk_page
);

   localparam int NUM_SEGS = 1 << SEG_BITS;
   localparam int ENTRIES  = 1 << IDX_BITS;

   initial assert (NUM_SEGS * ENTRIES <= 1024);

   logic [PAGE_W-1:0] row [NUM_SEGS][ENTRIES];

   for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
      logic seg_hit;
      assign seg_hit = wr_en && (seg == SEG_BITS'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) row[s][e] <= '0;
         end else if (seg_hit) begin
            row[s][wr_idx] <= wr_page;
         end
      end
   end

   assign rd_page = row[seg][rd_idx];
   assign lk_page = row[seg][lk_idx];

endmodule

// File: rtl/mmap_regfile.sv
module mmap_regfile
   import mmap_pkg::*;
#(
   parameter int SEG_BITS = 2,
   parameter int PAGE_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [7:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [3:0]        cpu_addr_hi,
   output logic [PAGE_W-1:0] phys_page,
   input  logic              cpu_fast,
   output logic [7:0]        win_offset,
   output logic              win_en,
   output logic              boot_ram,
   output logic              map_en,
   output logic [2:0]        clk_sel
);

   localparam int IDX_BITS = 4;
   localparam int ZPAD     = 8 - PAGE_W;

   initial assert (PAGE_W >= 5 && PAGE_W <= 8);

   logic [SEG_BITS-1:0] seg_q;
   logic [7:0]          win_q;
   mmap_flags_t         flags_q;
   logic [PAGE_W-1:0]   rd_page, lk_page, ident_page;
   logic [7:0]          entry_byte;
   logic                tbl_we;

   assign tbl_we = bus_we && (bus_addr[7:4] == TBL_NIB);

   mmap_ctrl #(.SEG_BITS(SEG_BITS), .WIN_W(8)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cpu_fast(cpu_fast), .seg_q(seg_q),
      .win_q(win_q), .flags_q(flags_q), .clk_sel(clk_sel)
   );

   mmap_table #(.SEG_BITS(SEG_BITS), .IDX_BITS(IDX_BITS), .PAGE_W(PAGE_W)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .seg(seg_q),
      .wr_idx(bus_addr[3:0]), .wr_page(bus_wdata[PAGE_W-1:0]),
      .rd_idx(bus_addr[3:0]), .rd_page(rd_page),
      .lk_idx(cpu_addr_hi), .lk_page(lk_page)
   );

   if (PAGE_W == 8) begin : g_full
      assign entry_byte = rd_page;
   end else begin : g_pad
      assign entry_byte = {{ZPAD{1'b0}}, rd_page};
   end

   assign ident_page = {{(PAGE_W-4){1'b0}}, cpu_addr_hi};
   assign phys_page  = flags_q.map_on ? lk_page : ident_page;

   always_comb begin
      bus_rdata = 8'hFF;
      if (bus_addr[7:4] == TBL_NIB) begin
         bus_rdata = entry_byte;
      end else begin
         case (bus_addr)
            OFF_SEG:   bus_rdata = {{(8-SEG_BITS){1'b0}}, seg_q};
            OFF_WIN:   bus_rdata = win_q;
            OFF_CTRL: begin
               bus_rdata = CTRL_FILL;
               bus_rdata[CTRL_MAP]  = flags_q.map_on;
               bus_rdata[CTRL_WIN]  = flags_q.win_on;
               bus_rdata[CTRL_BOOT] = flags_q.boot_ram;
            end
            OFF_SPEED: bus_rdata = SPEED_FILL | {7'd0, flags_q.fast_map};
            default:   bus_rdata = 8'hFF;
         endcase
      end
   end

   assign win_offset = win_q;
   assign win_en     = flags_q.win_on;
   assign boot_ram   = flags_q.boot_ram;
   assign map_en     = flags_q.map_on;

   AST_IDENT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !map_en |-> (phys_page[PAGE_W-1:4] == '0)); // R6
   AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFF_CTRL) |=> (map_en == $past(bus_wdata[CTRL_MAP]))); // R4

endmodule

// File: tb/mmap_regfile_bench.sv
module mmap_regfile_bench;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       bus_we = 0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [3:0] cpu_addr_hi = 4'h0;
   logic [5:0] phys_page;
   logic       cpu_fast = 0;
   logic [7:0] win_offset;
   logic       win_en, boot_ram, map_en;
   logic [2:0] clk_sel;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mmap_regfile u_mmap_regfile (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_addr_hi(cpu_addr_hi),
      .phys_page(phys_page), .cpu_fast(cpu_fast), .win_offset(win_offset),
      .win_en(win_en), .boot_ram(boot_ram), .map_en(map_en), .clk_sel(clk_sel)
   );

   // {write, offset, write data, expected read}
   localparam int NV = 15;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 8'h80, 8'h3F, 8'h3F},   // R1 entry 0, seg 0
      {1'b1, 8'h8F, 8'hFF, 8'h3F},   // R1 upper bits dropped
      {1'b1, 8'h85, 8'h2A, 8'h2A},   // R1
      {1'b1, 8'h90, 8'hFE, 8'h02},   // R2 seg 2 from low bits
      {1'b0, 8'h80, 8'h00, 8'h00},   // R2 fresh segment is empty
      {1'b1, 8'h80, 8'h11, 8'h11},   // R2 write in seg 2
      {1'b1, 8'h90, 8'h00, 8'h00},   // R2 back to seg 0
      {1'b0, 8'h80, 8'h00, 8'h3F},   // R2 seg 0 untouched
      {1'b1, 8'h92, 8'hA5, 8'hA5},   // R3
      {1'b1, 8'h93, 8'hFF, 8'hFF},   // R4 all flags
      {1'b1, 8'h93, 8'h40, 8'h7E},   // R4 window only
      {1'b1, 8'h93, 8'h01, 8'h3F},   // R4 boot only
      {1'b1, 8'h94, 8'h01, 8'hFF},   // R5
      {1'b1, 8'h94, 8'hFE, 8'hFE},   // R5 clear
      {1'b1, 8'h91, 8'h55, 8'hFF}    // R9 unused offset
   };

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      bus_addr = a; #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic edge_wait;
      @(posedge clk); #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      edge_wait();
      // R8 reset state
      rd_chk("R8 seg", 8'h90, 8'h00);
      rd_chk("R8 win", 8'h92, 8'h00);
      rd_chk("R8 ctrl", 8'h93, 8'h3E);
      rd_chk("R8 speed", 8'h94, 8'hFE);
      rd_chk("R8 entry", 8'h8C, 8'h00);
      check("R8 clk_sel", clk_sel, 0);
      check("R8 flags", {map_en, win_en, boot_ram}, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
         rd_chk($sformatf("vector %0d", i), VEC[i][23:16], VEC[i][7:0]);
      end
      // R9 unused offset write left registers intact
      rd_chk("R9 seg after 0x91", 8'h90, 8'h00);
      rd_chk("R9 win after 0x91", 8'h92, 8'hA5);
      rd_chk("R9 low offset", 8'h00, 8'hFF);
      // R3 pin, R4 pins
      check("R3 win_offset", win_offset, 8'hA5);
      check("R4 pins", {map_en, win_en, boot_ram}, 3'b001);

      // R6 lookup
      cpu_addr_hi = 4'hB; #1;
      check("R6 identity", phys_page, 6'h0B);
      wr(8'h8B, 8'h2C);
      wr(8'h93, 8'h80);
      check("R6 mapped seg0", phys_page, 6'h2C);
      check("R7 map slow", clk_sel, 2);
      wr(8'h90, 8'h01);
      check("R6 mapped seg1", phys_page, 6'h00);
      wr(8'h90, 8'h00);
      cpu_addr_hi = 4'h5; #1;
      check("R6 mapped nib5", phys_page, 6'h2A);

      // R7 clock codes
      @(negedge clk); cpu_fast = 1; edge_wait();
      check("R7 map fast", clk_sel, 3);
      wr(8'h94, 8'h01);
      check("R7 fastmap fast", clk_sel, 5);
      @(negedge clk); cpu_fast = 0; edge_wait();
      check("R7 fastmap slow", clk_sel, 4);
      wr(8'h93, 8'h00);
      check("R7 map off slow", clk_sel, 0);
      @(negedge clk); cpu_fast = 1; edge_wait();
      check("R7 map off fast", clk_sel, 1);
      check("R6 identity again", phys_page, 6'h05);

      // R8 reset again clears everything
      @(negedge clk); rst_n = 0; #1;
      check("R8 clk_sel in reset", clk_sel, 0);
      rd_chk("R8 entry cleared", 8'h8B, 8'h00);
      rd_chk("R8 speed cleared", 8'h94, 8'hFE);
      @(negedge clk); rst_n = 1;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule